// File: doc/BRIEF.md
# Two-Phase Toggle Handshake Link

This block moves parallel data words between two unrelated clock domains using transition signalling. On the sending side, a producer offers words through a valid/ready port. The sender holds each word on a shared data bus. After a settle interval it inverts a request level. On the receiving side, a change in the synchronised request level means a new word is present. The receiver captures the word and offers it to a consumer through a second valid/ready port. Only after the consumer has taken the word does the receiver invert an acknowledge level. The sender treats any change of the synchronised acknowledge as completion, and it then accepts the next word.

The link carries exactly one word per request/acknowledge transition pair, with no return-to-zero phase. Each side detects an event by comparing the synchronised incoming level against a level it stored earlier. Because of this, a slow or stalled peer can never cause a lost or doubled word. Both handshake levels enter their destination domain through a chain of flip-flops, by default two. The data bus is not synchronised. Its stability is guaranteed by the protocol ordering instead.

Top module: `toggle_link`

## Requirements
- R1: After reset, the producer port shows `s_ready` = 1 and the consumer port shows `m_valid` = 0; both internal handshake levels and their stored comparison levels are 0.
- R2: A word is accepted on a `clk_tx` edge where `s_valid` and `s_ready` are both 1. `s_ready` is 0 from the next cycle until that word's acknowledge change has been observed, so at most one word is in flight.
- R3: The data bus holds the accepted word unchanged for at least `SETTLE_CYC` (≥1) `clk_tx` cycles before the request level inverts, and it stays unchanged until the acknowledge change is seen.
- R4: The request level inverts exactly once per accepted word, and never while `s_ready` is 1.
- R5: Each request change produces exactly one word at the consumer port. While `m_valid` = 1 and `m_ready` = 0, `m_valid` stays 1 and `m_data` does not change.
- R6: The acknowledge level inverts only in the cycle after the consumer takes a word (`m_valid` and `m_ready` both 1). While the consumer stalls, the producer port keeps `s_ready` = 0.
- R7: Words reach the consumer in the order they were accepted, with no loss and no duplicate, at any ratio of the two clock frequencies and under arbitrary consumer stalls.
- R8: After the consumer takes the last outstanding word, `s_ready` returns to 1 without further producer action.
- R9: With no word offered by the producer, `m_valid` stays 0 indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | Sending-side clock |
| rst_tx | input | 1 | Synchronous active-high reset, sending side |
| s_valid | input | 1 | Producer offers a word |
| s_ready | output | 1 | Sender can accept a word |
| s_data | input | DATA_W | Producer word |
| clk_rx | input | 1 | Receiving-side clock |
| rst_rx | input | 1 | Synchronous active-high reset, receiving side |
| m_valid | output | 1 | Word available to consumer |
| m_ready | input | 1 | Consumer takes the word |
| m_data | output | DATA_W | Delivered word |

## Verification
The bench runs the receive clock equal to, much slower than, and faster than the send clock. At each ratio, producer gaps and consumer stalls are random, and every delivered word is checked against the order in which it was accepted. If a design compared against the wrong stored level, or updated that level at the wrong time, it would deliver a word twice or skip one, and the scoreboard would see a mismatch. In a separate test the consumer stalls for a long time. A design that inverted the acknowledge on capture rather than on consumption would raise `s_ready` during that stall. A further idle stretch exposes any receiver that produces a phantom word from reset-level mismatch.

// File: rtl/toggle_link_pkg.sv
package toggle_link_pkg;

  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_SETTLE = 2'd1,
    TX_WAIT   = 2'd2
  } tx_state_e;

  localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/tl_level_sync.sv
module tl_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/tl_sender.sv
module tl_sender
  import toggle_link_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SETTLE_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              ack_sync
);

  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  tx_state_e        state;
  logic             ack_seen;
  logic [CNT_W-1:0] settle_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= TX_IDLE;
      s_ready    <= 1'b1;
      req_o      <= 1'b0;
      ack_seen   <= 1'b0;
      data_o     <= '0;
      settle_cnt <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (s_valid) begin
            data_o     <= s_data;
            s_ready    <= 1'b0;
            settle_cnt <= CNT_W'(SETTLE_CYC - 1);
            state      <= TX_SETTLE;
          end
        end
        TX_SETTLE: begin
          if (settle_cnt == '0) begin
            ack_seen <= ack_sync;
            req_o    <= ~req_o;
            state    <= TX_WAIT;
          end else begin
            settle_cnt <= settle_cnt - 1'b1;
          end
        end
        TX_WAIT: begin
          if (ack_sync != ack_seen) begin
            ack_seen <= ack_sync;
            s_ready  <= 1'b1;
            state    <= TX_IDLE;
          end
        end
        default: begin
          state   <= TX_IDLE;
          s_ready <= 1'b1;
        end
      endcase
    end
  end

  // R2: an accepted word closes the producer port on the next cycle
  p_one_in_flight_r2: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  // R3: bus word unchanged across the request inversion
  p_data_settled_r3: assert property (@(posedge clk) disable iff (rst)
    (req_o != $past(req_o)) |-> $stable(data_o));

  // R3: bus word unchanged while waiting for acknowledge
  p_data_held_r3: assert property (@(posedge clk) disable iff (rst)
    (!s_ready && !$past(s_ready)) |-> $stable(data_o));

  // R4: request never inverts while the port is open
  p_req_only_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (req_o != $past(req_o)) |-> !s_ready);

endmodule

// File: rtl/tl_receiver.sv
module tl_receiver #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_sync,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);

  logic req_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_seen <= 1'b0;
      ack_o    <= 1'b0;
      m_valid  <= 1'b0;
      m_data   <= '0;
    end else if (m_valid) begin
      if (m_ready) begin
        m_valid <= 1'b0;
        ack_o   <= ~ack_o;
      end
    end else if (req_sync != req_seen) begin
      req_seen <= req_sync;
      m_data   <= data_i;
      m_valid  <= 1'b1;
    end
  end

  // R5: an offered word is held until taken
  p_hold_word_r5: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R6: acknowledge moves only after consumption
  p_ack_after_take_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_o != $past(ack_o)) |-> $past(m_valid && m_ready));

  // R5: a taken word is not offered again in the next cycle
  p_no_repeat_r5: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready) |=> !m_valid);

endmodule

// File: rtl/toggle_link.sv
module toggle_link
  import toggle_link_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SETTLE_CYC  = 1,
  parameter int SYNC_STAGES = MIN_SYNC_STAGES
) (
  input  logic              clk_tx,
  input  logic              rst_tx,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              clk_rx,
  input  logic              rst_rx,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);

  logic              req_lvl;
  logic              ack_lvl;
  logic              req_in_rx;
  logic              ack_in_tx;
  logic [DATA_W-1:0] bus_data;

  tl_sender #(
    .DATA_W     (DATA_W),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_tx (
    .clk      (clk_tx),
    .rst      (rst_tx),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_data   (s_data),
    .req_o    (req_lvl),
    .data_o   (bus_data),
    .ack_sync (ack_in_tx)
  );

  tl_level_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk (clk_rx),
    .rst (rst_rx),
    .d   (req_lvl),
    .q   (req_in_rx)
  );

  tl_level_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk (clk_tx),
    .rst (rst_tx),
    .d   (ack_lvl),
    .q   (ack_in_tx)
  );

  tl_receiver #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk_rx),
    .rst      (rst_rx),
    .req_sync (req_in_rx),
    .data_i   (bus_data),
    .ack_o    (ack_lvl),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_data   (m_data)
  );

  // R9: the consumer port is idle right after reset
  p_quiet_after_reset_r9: assert property (@(posedge clk_rx) disable iff (rst_rx)
    $past(rst_rx) |-> !m_valid);

endmodule

// File: tb/toggle_link_test.sv
`timescale 1ns/1ps
module toggle_link_test;

  localparam int DW = 16;

  logic          clk_tx = 1'b0;
  logic          clk_rx = 1'b0;
  logic          rst_tx = 1'b1;
  logic          rst_rx = 1'b1;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_data = '0;
  logic          m_valid;
  logic          m_ready = 1'b0;
  logic [DW-1:0] m_data;

  realtime rx_half = 2.5;
  int checks = 0;
  int errors = 0;
  int stall_pct = 0;
  bit hold_rdy = 1'b0;
  bit pend = 1'b0;
  logic [DW-1:0] pend_data;
  logic [DW-1:0] expq[$];

  always #2.5 clk_tx = ~clk_tx;
  initial forever #(rx_half) clk_rx = ~clk_rx;

  toggle_link #(.DATA_W(DW)) uut (
    .clk_tx (clk_tx), .rst_tx (rst_tx), .s_valid (s_valid), .s_ready (s_ready),
    .s_data (s_data), .clk_rx (clk_rx), .rst_rx (rst_rx), .m_valid (m_valid),
    .m_ready (m_ready), .m_data (m_data)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop and hold checks, sampled at rx negedge
  initial begin
    @(negedge clk_rx);
    while (rst_rx) @(negedge clk_rx);
    forever begin
      @(negedge clk_rx);
      if (pend) begin
        check(m_valid && (m_data == pend_data), "R5 stalled word held", m_data, pend_data);
        pend = 1'b0;
      end
      m_ready = hold_rdy ? 1'b0 : (int'($urandom_range(99)) >= stall_pct);
      if (m_valid && m_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R7 unexpected word", m_data, '0);
        end else begin
          logic [DW-1:0] e;
          e = expq.pop_front();
          check(m_data == e, "R7 order/duplicate", m_data, e);
        end
      end else if (m_valid) begin
        pend = 1'b1;
        pend_data = m_data;
      end
    end
  end

  task automatic send_word(input logic [DW-1:0] d);
    @(negedge clk_tx);
    s_valid = 1'b1;
    s_data  = d;
    while (!s_ready) @(negedge clk_tx);
    expq.push_back(d);
    @(negedge clk_tx);
    s_valid = 1'b0;
    check(!s_ready, "R2 port closes after accept", {15'd0, s_ready}, '0);
  endtask

  task automatic drain();
    while (expq.size() != 0 || m_valid) @(negedge clk_tx);
    repeat (20) @(negedge clk_tx);
    check(s_ready, "R8 port reopens after drain", {15'd0, s_ready}, 16'd1);
  endtask

  task automatic run_phase(input int ph, input int n, input int gap, input int stall);
    stall_pct = stall;
    for (int i = 0; i < n; i++) begin
      send_word({ph[3:0], i[11:0]});
      repeat ($urandom_range(gap)) @(negedge clk_tx);
    end
    drain();
  endtask

  initial begin
    repeat (6) @(posedge clk_tx);
    @(negedge clk_tx) rst_tx = 1'b0;
    @(negedge clk_rx) rst_rx = 1'b0;
    @(negedge clk_tx);
    // R1: reset state visible at the ports
    check(s_ready == 1'b1, "R1 s_ready after reset", {15'd0, s_ready}, 16'd1);
    check(m_valid == 1'b0, "R1 m_valid after reset", {15'd0, m_valid}, '0);

    // R9: no phantom word while idle
    begin
      bit quiet = 1'b1;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk_rx);
        if (m_valid) quiet = 1'b0;
      end
      check(quiet, "R9 idle consumer port", {15'd0, !quiet}, '0);
    end

    // R7: equal clocks, then slow rx, then fast rx
    run_phase(1, 30, 4, 30);
    rx_half = 7.0;
    run_phase(2, 30, 0, 50);
    rx_half = 1.3;
    run_phase(3, 30, 3, 20);
    rx_half = 3.1;
    run_phase(4, 30, 0, 0);

    // R6: long consumer stall keeps the producer port closed
    hold_rdy = 1'b1;
    send_word(16'hA5C3);
    repeat (60) @(negedge clk_tx);
    check(m_valid == 1'b1, "R6 word waiting at consumer", {15'd0, m_valid}, 16'd1);
    check(s_ready == 1'b0, "R6 no ack during stall", {15'd0, s_ready}, '0);
    hold_rdy = 1'b0;
    drain();

    // R9: quiet again after traffic
    begin
      bit quiet = 1'b1;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk_rx);
        if (m_valid) quiet = 1'b0;
      end
      check(quiet, "R9 idle after traffic", {15'd0, !quiet}, '0);
    end
    check(expq.size() == 0, "R7 nothing lost", 16'(expq.size()), '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500us;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule